// File: doc/BRIEF.md
# Auto-Reload 16-bit Timer/Counter

This block is a 16-bit up-counter that can count in two ways. In timer mode it advances once every twelve system clocks. In counter mode it advances once for each falling edge on an external count pin. A run bit starts and stops it. A gate bit can also make counting depend on an external gate pin being high. When the count passes its all-ones value it does not roll over to zero. Instead it reloads from a 16-bit reload register and sets an overflow flag, which an interrupt controller sees.

Software reaches the block through a small byte-wide register bus. Writes take effect at the next clock edge. Reads are combinational. The interrupt controller clears the flag with a one-cycle acknowledge input when it vectors to the timer handler.

Top module: `ar16_timer`

## Requirements
- R1: After reset, the count, the reload value and the control register all read zero, and the overflow flag is low.
- R2: In timer mode (control bit 6 = 0, run bit 4 = 1), the count advances by exactly 10 over any 120 consecutive clocks.
- R3: In counter mode (control bit 6 = 1), each falling edge of the count pin adds one to the count, no later than the third clock edge after the pin changes. Rising edges add nothing.
- R4: While the run bit (control bit 4) is 0, the count holds its value.
- R5: With the gate bit (control bit 7) at 1, events are counted only while the gate pin is high. With the gate bit at 0, the gate pin has no effect.
- R6: The low byte carries into the high byte, so the 16-bit count steps as one value (00FF to 0100, 7FFF to 8000).
- R7: A count event at FFFF loads the count from the reload register, and the reload register keeps its value.
- R8: The overflow flag (control bit 5, also on `ovf_flag`) is set on the edge that reloads the count. It stays set until `flag_clr` is pulsed or software writes the bit.
- R9: If an overflow and `flag_clr` fall in the same cycle, the flag ends up set.
- R10: The control register holds gate (bit 7), source (bit 6), flag (bit 5), run (bit 4) and four interrupt-pin bits (bits 3..0), all readable and writable. A software write to bit 5 sets or clears the flag.
- R11: Bus addresses: 0 is the count low byte, 1 the count high byte, 2 the reload low byte, 3 the reload high byte, 4 the control register. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, takes effect at the next clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cnt_pin | input | 1 | External count input (falling edges counted) |
| gate_pin | input | 1 | External gate input |
| flag_clr | input | 1 | Overflow-flag acknowledge from the interrupt controller |
| ovf_flag | output | 1 | Overflow flag |

## Verification
Each result is due at a known clock edge:
- A register write shows on `bus_rdata` right after the edge that takes it.
- A falling edge on the count pin changes the count on the third rising edge after the change, because the pin passes through two synchroniser flops and one edge-detect flop.
- A change on the gate pin is seen after two edges.
- An overflow reloads the count and sets the flag on the same edge.

The bench drives inputs and samples outputs on falling clock edges, and waits at least those edge counts before each comparison. In timer mode the prescaler phase is free-running, so the check uses a 120-clock window, which holds exactly ten ticks whatever the phase.

// File: rtl/ar16_pkg.sv
package ar16_pkg;

  // Control register layout, MSB first: gate, source, flag, run, four interrupt-pin bits
  typedef struct packed {
    logic       gate;
    logic       src;
    logic       flag;
    logic       run;
    logic [3:0] irq_bits;
  } ctrl_t;

  localparam int AR16_CNT_W = 16;
  localparam int AR16_DIV   = 12;

endpackage

// File: rtl/ar16_prescale.sv
module ar16_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ar16_sync.sv
module ar16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ar16_count_core.sv
module ar16_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W/8-1:0] cnt_we,
  input  logic [CNT_W/8-1:0] rld_we,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             inc_evt,
  output logic             wrap
);
  localparam int NB = CNT_W / 8;

  // Increment with carry-out; the carry marks the overflow
  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] rld_d;

  assign sum     = step(cnt_q);
  assign inc_evt = evt && (cnt_we == '0);   // a software write wins over counting
  assign wrap    = inc_evt && sum[CNT_W];

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    if (inc_evt) cnt_d = wrap ? rld_q : sum[CNT_W-1:0];
    for (int i = 0; i < NB; i++) begin
      if (cnt_we[i]) cnt_d[i*8 +: 8] = wdata;
      if (rld_we[i]) rld_d[i*8 +: 8] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end
endmodule

// File: rtl/ar16_timer.sv
module ar16_timer
  import ar16_pkg::*;
#(
  parameter int CNT_W       = AR16_CNT_W,
  parameter int DIV         = AR16_DIV,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              flag_clr,
  output logic              ovf_flag
);
  localparam int NB       = CNT_W / 8;
  localparam int CTL_ADDR = 2 * NB;

  ctrl_t            ctrl_q, ctrl_d;
  logic [NB-1:0]    cnt_we, rld_we;
  logic             ctl_we;
  logic             cnt_we_any, rld_we_any;
  logic             tick, cpin_s, cpin_prev, pin_fall, gate_s;
  logic             run_en, src_evt, evt, inc_evt, wrap;
  logic [CNT_W-1:0] cnt_q, rld_q;

  // Write decode, one strobe per byte lane
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign cnt_we[i] = bus_wr && (bus_addr == ADDR_W'(i));
    assign rld_we[i] = bus_wr && (bus_addr == ADDR_W'(NB + i));
  end
  assign ctl_we     = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));
  assign cnt_we_any = |cnt_we;
  assign rld_we_any = |rld_we;

  ar16_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  ar16_sync #(.STAGES(SYNC_STAGES)) u_cpin (
    .clk(clk), .rst_n(rst_n), .d(cnt_pin), .q(cpin_s));

  ar16_sync #(.STAGES(SYNC_STAGES)) u_gpin (
    .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpin_prev <= 1'b0;
    else        cpin_prev <= cpin_s;
  end
  assign pin_fall = cpin_prev && !cpin_s;

  // Count enable: the run bit, plus the gate pin when the gate bit is set
  assign run_en  = ctrl_q.run && (!ctrl_q.gate || gate_s);
  assign src_evt = ctrl_q.src ? pin_fall : tick;
  assign evt     = run_en && src_evt;

  ar16_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .cnt_we(cnt_we), .rld_we(rld_we), .wdata(bus_wdata),
    .cnt_q(cnt_q), .rld_q(rld_q), .inc_evt(inc_evt), .wrap(wrap));

  // Flag priority, lowest to highest: acknowledge, software write, overflow
  always_comb begin
    ctrl_d = ctrl_q;
    if (flag_clr) ctrl_d.flag = 1'b0;
    if (ctl_we)   ctrl_d = ctrl_t'(bus_wdata);
    if (wrap)     ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ovf_flag = ctrl_q.flag;

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == ADDR_W'(i))      bus_rdata = cnt_q[i*8 +: 8];
      if (bus_addr == ADDR_W'(NB + i)) bus_rdata = rld_q[i*8 +: 8];
    end
    if (bus_addr == ADDR_W'(CTL_ADDR)) bus_rdata = ctrl_q;
  end
endmodule

// File: rtl/ar16_timer_chk.sv
module ar16_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             gate,
  input logic             gate_s,
  input logic             tick,
  input logic             inc_evt,
  input logic             wrap,
  input logic             flag,
  input logic             flag_clr,
  input logic             ctl_we,
  input logic             cnt_we_any,
  input logic             rld_we_any,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q
);
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);                                                  // R2
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we_any) |=> $stable(cnt_q));                        // R4
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_s) |-> !inc_evt);                                  // R5
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !wrap) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));      // R6
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(rld_q));                                  // R7
  AST_RELOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_we_any |=> $stable(rld_q));                                  // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);                                                   // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr && !ctl_we) |=> flag);                         // R8
  AST_FLAG_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && flag_clr) |=> flag);                                     // R9
endmodule

bind ar16_timer ar16_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .gate(ctrl_q.gate),
  .gate_s(gate_s), .tick(tick), .inc_evt(inc_evt), .wrap(wrap),
  .flag(ovf_flag), .flag_clr(flag_clr), .ctl_we(ctl_we),
  .cnt_we_any(cnt_we_any), .rld_we_any(rld_we_any),
  .cnt_q(cnt_q), .rld_q(rld_q));

// File: tb/ar16_timer_bench.sv
module ar16_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_pin = 1'b1;
  logic       gate_pin = 1'b0;
  logic       flag_clr = 1'b0;
  logic       ovf_flag;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ar16_timer u_ar16_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .flag_clr(flag_clr), .ovf_flag(ovf_flag));

  // Fields: start count, reload, falling edges, expected count, expected flag
  localparam logic [52:0] VEC [5] = '{
    {16'h0000, 16'h0000, 4'd3, 16'h0003, 1'b0},  // R3
    {16'h00FE, 16'h0000, 4'd2, 16'h0100, 1'b0},  // R6
    {16'hFFFF, 16'h1234, 4'd1, 16'h1234, 1'b1},  // R7
    {16'hFFFE, 16'hABCD, 4'd3, 16'hABCE, 1'b1},  // R7
    {16'h7FFF, 16'h0000, 4'd1, 16'h8000, 1'b0}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
      cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic clr_flag;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  task automatic set_rld(input logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  initial begin
    #(8 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      check("R1 reg", {8'h00, b}, 16'h0000);
    end
    check("R1 flag", {15'b0, ovf_flag}, 16'h0000);

    // R11: register map
    set_rld(16'hC35A);
    rd(3'd2, b); check("R11 rld lo", {8'h00, b}, 16'h005A);
    rd(3'd3, b); check("R11 rld hi", {8'h00, b}, 16'h00C3);
    rd(3'd6, b); check("R11 unmapped", {8'h00, b}, 16'h0000);
    // R10: interrupt-pin bits stored; run off so nothing counts
    wr(3'd4, 8'h0A);
    rd(3'd4, b); check("R10 irq bits", {8'h00, b}, 16'h000A);

    // Table walk in counter mode: source=1, run=1
    wr(3'd4, 8'h50);
    for (int v = 0; v < 5; v++) begin
      clr_flag();
      set_cnt(VEC[v][52:37]);
      set_rld(VEC[v][36:21]);
      pulse(int'(VEC[v][20:17]));
      rd_cnt(c1);
      check("R3/R6/R7 count", c1, VEC[v][16:1]);
      check("R8 flag", {15'b0, ovf_flag}, {15'b0, VEC[v][0]});
    end
    rd(3'd3, b); check("R7 reload kept", {8'h00, b}, 16'h0000);

    // R4: run off, pin edges ignored
    set_cnt(16'h0100);
    wr(3'd4, 8'h40);
    pulse(2);
    rd_cnt(c1); check("R4 stopped", c1, 16'h0100);

    // R5: gate bit set, gate pin low blocks, high allows
    wr(3'd4, 8'hD0);
    gate_pin = 1'b0;
    repeat (3) @(negedge clk);
    pulse(2);
    rd_cnt(c1); check("R5 gated off", c1, 16'h0100);
    gate_pin = 1'b1;
    repeat (3) @(negedge clk);
    pulse(2);
    rd_cnt(c1); check("R5 gated on", c1, 16'h0102);
    gate_pin = 1'b0;
    wr(3'd4, 8'h50);
    repeat (3) @(negedge clk);
    pulse(1);
    rd_cnt(c1); check("R5 gate bit clear", c1, 16'h0103);

    // R3: exact latency, count moves on the third edge, not the second
    @(negedge clk); cnt_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    rd_cnt(c1); check("R3 not yet", c1, 16'h0103);
    @(negedge clk);
    rd_cnt(c1); check("R3 third edge", c1, 16'h0104);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd_cnt(c1); check("R3 rising ignored", c1, 16'h0104);

    // R2: timer mode, ten ticks in any 120 clocks
    wr(3'd4, 8'h10);
    @(negedge clk);
    rd_cnt(c0);
    repeat (120) @(negedge clk);
    rd_cnt(c1);
    check("R2 prescale", c1 - c0, 16'd10);

    // R10 + R9: software sets flag, then overflow and acknowledge coincide
    wr(3'd4, 8'h40);
    set_cnt(16'hFFFF);
    set_rld(16'h0042);
    wr(3'd4, 8'h70);
    check("R10 flag write", {15'b0, ovf_flag}, 16'h0001);
    @(negedge clk); cnt_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R9 flag kept", {15'b0, ovf_flag}, 16'h0001);
    rd_cnt(c1); check("R7 reloaded", c1, 16'h0042);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 flag holds", {15'b0, ovf_flag}, 16'h0001);
    clr_flag();
    check("R8 acknowledge", {15'b0, ovf_flag}, 16'h0000);
    wr(3'd4, 8'h20);
    check("R10 sw set", {15'b0, ovf_flag}, 16'h0001);
    wr(3'd4, 8'h00);
    check("R10 sw clear", {15'b0, ovf_flag}, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule